// File: doc/BRIEF.md
# Request-Paced Transfer Gate

This block sits beside a DMA channel's datapath and decides, cycle by cycle, whether the channel may move bytes. A software start (`go`) arms the channel. If external start is enabled, the channel then waits for a board-level start pin before any byte moves. Once running, the datapath raises `byte_adv` for every byte it moves. `byte_adv` counts only while `xfer_ok` is high.

With request pacing enabled, the channel moves a burst of 2^n bytes and then parks in a paused state. It leaves that state only when the active-low request pin shows a new falling edge. Both pins are brought into the clock domain through synchronisers. A `xfer_done` pulse from the descriptor logic ends the transfer at any point and clears the burst count.

Top module: `xfer_pace_gate`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `xfer_ok` and `paused` are both 0.
- R2: With `ext_start_en` = 0, a `go` pulse taken while the channel is idle makes `xfer_ok` high from the next cycle.
- R3: With `ext_start_en` = 1, a `go` pulse only arms the channel and `xfer_ok` stays 0. After `start_pin` goes high, the pin passes through a 2-stage synchroniser and `xfer_ok` rises at the third clock edge after the pin went high.
- R4: `req_log2` is a 4-bit field holding n, and a burst is 2^n bytes. With `ext_pause_en` = 1 and n ≠ 0, the 2^n-th counted byte of a burst drops `xfer_ok` and raises `paused` at that same clock edge.
- R5: Field values above 10 are treated as 10, so the largest burst is 1024 bytes.
- R6: With `ext_pause_en` = 0, or with `req_log2` = 0, bytes flow without ever pausing.
- R7: A paused channel resumes only on a falling edge of `dreq_n`, seen after a 2-stage synchroniser. It resumes three clock edges after the pin falls. A low level that was already present when the pause began does not resume it. Edges that occur while the channel is not paused are ignored.
- R8: `byte_adv` is ignored while `xfer_ok` is 0. Strobes given during a pause or a wait do not shorten the next burst.
- R9: A `xfer_done` pulse returns the gate to idle and clears the burst count, so the next transfer starts with a full burst. If `go` arrives in the same cycle as `xfer_done`, `xfer_done` wins.
- R10: `paused` stays 0 while the channel is idle, running or waiting for its start pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_start_en | input | 1 | Hold the armed channel until `start_pin` asserts |
| ext_pause_en | input | 1 | Enable request pacing |
| req_log2 | input | 4 | Burst size exponent n (2^n bytes); 0 disables pacing |
| go | input | 1 | Software start pulse |
| xfer_done | input | 1 | End-of-transfer pulse from the descriptor logic |
| start_pin | input | 1 | External start pin, active high, asynchronous |
| dreq_n | input | 1 | External request pin, active low, asynchronous |
| byte_adv | input | 1 | One byte moved by the datapath this cycle |
| xfer_ok | output | 1 | Channel may move bytes |
| paused | output | 1 | Burst finished, waiting for a new request edge |

## Verification
The bench builds the gate with its default parameters: 2 synchroniser stages and a maximum exponent of 10. With these values a clamped field of 15 is reached in about a thousand cycles, so the full 1024-byte burst and the clamp are both exercised. A short burst of 4 bytes is used to probe several timing cases:
- the exact edge on which the gate pauses;
- a request level that was already low when the pause began;
- strobes given during a pause;
- a transfer that ends partway through a burst.

The three-edge latency of both pins is checked against a model that keeps a sample history of each pin.

// File: rtl/pace_pkg.sv
package pace_pkg;
    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_WAIT = 2'd1,
        PG_RUN  = 2'd2,
        PG_HOLD = 2'd3
    } pg_state_e;
endpackage

// File: rtl/pace_sync.sv
module pace_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pace_limit.sv
module pace_limit #(
    parameter int FW       = 4,
    parameter int MAX_LOG2 = 10,
    localparam int CW      = MAX_LOG2
) (
    input  logic [FW-1:0] field,
    output logic [CW-1:0] term,
    output logic          active
);
    logic [FW-1:0] lim;
    logic [CW:0]   one_sh;

    always_comb begin
        lim    = (int'(field) > MAX_LOG2) ? FW'(MAX_LOG2) : field;
        one_sh = (CW+1)'(1) << lim;
        term   = one_sh[CW-1:0] - CW'(1);
        active = (field != '0);
    end
endmodule

// File: rtl/xfer_pace_gate.sv
module xfer_pace_gate
    import pace_pkg::*;
#(
    parameter int FW          = 4,
    parameter int MAX_LOG2    = 10,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = MAX_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_start_en,
    input  logic          ext_pause_en,
    input  logic [FW-1:0] req_log2,
    input  logic          go,
    input  logic          xfer_done,
    input  logic          start_pin,
    input  logic          dreq_n,
    input  logic          byte_adv,
    output logic          xfer_ok,
    output logic          paused
);
    typedef struct packed {
        pg_state_e     st;
        logic [CW-1:0] cnt;
        logic          dreq_prev;
    } gate_t;

    gate_t   s_d, s_q;
    logic    start_s, dreq_s;
    logic [CW-1:0] term;
    logic    field_on, pace_on, req_fall;

    pace_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_start (
        .clk(clk), .rst_n(rst_n), .d(start_pin), .q(start_s));
    pace_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_req (
        .clk(clk), .rst_n(rst_n), .d(dreq_n), .q(dreq_s));

    pace_limit #(.FW(FW), .MAX_LOG2(MAX_LOG2)) u_limit (
        .field(req_log2), .term(term), .active(field_on));

    always_comb begin
        s_d          = s_q;
        s_d.dreq_prev = dreq_s;
        req_fall     = s_q.dreq_prev & ~dreq_s;
        pace_on      = ext_pause_en & field_on;
        if (xfer_done) begin
            s_d.st  = PG_IDLE;
            s_d.cnt = '0;
        end else begin
            unique case (s_q.st)
                PG_IDLE: if (go) s_d.st = ext_start_en ? PG_WAIT : PG_RUN;
                PG_WAIT: if (start_s) s_d.st = PG_RUN;
                PG_RUN: begin
                    if (byte_adv && pace_on) begin
                        if (s_q.cnt == term) begin
                            s_d.st  = PG_HOLD;
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt = s_q.cnt + CW'(1);
                        end
                    end
                end
                PG_HOLD: if (req_fall) s_d.st = PG_RUN;
                default: s_d.st = PG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: PG_IDLE, cnt: '0, dreq_prev: 1'b1};
        else        s_q <= s_d;
    end

    assign xfer_ok = (s_q.st == PG_RUN);
    assign paused  = (s_q.st == PG_HOLD);
endmodule

// File: rtl/xfer_pace_gate_chk.sv
module xfer_pace_gate_chk #(
    parameter int FW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ext_start_en,
    input logic          ext_pause_en,
    input logic [FW-1:0] req_log2,
    input logic          xfer_done,
    input logic          byte_adv,
    input logic          start_s,
    input logic          xfer_ok,
    input logic          paused
);
    // R4
    pause_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(byte_adv && xfer_ok && ext_pause_en && (req_log2 != '0)));
    // R7
    pause_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(paused) |-> ($past(xfer_done) || xfer_ok));
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_done) |-> (!xfer_ok && !paused));
    // R3
    ext_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ok && !$past(xfer_ok) && !$past(paused) && $past(ext_start_en)) |-> $past(start_s));
endmodule

bind xfer_pace_gate xfer_pace_gate_chk #(.FW(FW)) u_chk (.*);

// File: tb/xfer_pace_gate_tb.sv
`timescale 1ns/1ps
module xfer_pace_gate_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_start_en = 1'b0, ext_pause_en = 1'b0;
    logic [3:0] req_log2 = 4'd0;
    logic go = 1'b0, xfer_done = 1'b0, start_pin = 1'b0, dreq_n = 1'b1, byte_adv = 1'b0;
    logic xfer_ok, paused;

    int n_run = 0, n_fail = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    xfer_pace_gate u_dut (.*);

    // behavioural reference model
    int m_mode = 0;   // 0 idle, 1 waiting for start, 2 moving, 3 paused
    int m_bytes = 0;
    int q_req[$] = '{1, 1, 1};
    int q_st[$]  = '{0, 0};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_bytes = 0;
            q_req = '{1, 1, 1}; q_st = '{0, 0};
        end else begin
            int n, burst;
            bit fall, st_hi, pace;
            fall  = (q_req[2] == 1) && (q_req[1] == 0);
            st_hi = (q_st[1] == 1);
            n     = (req_log2 > 10) ? 10 : int'(req_log2);
            burst = 1 << n;
            pace  = ext_pause_en && (req_log2 != 0);
            if (xfer_done) begin
                m_mode = 0; m_bytes = 0;
            end else if (m_mode == 0) begin
                if (go) m_mode = ext_start_en ? 1 : 2;
            end else if (m_mode == 1) begin
                if (st_hi) m_mode = 2;
            end else if (m_mode == 2) begin
                if (byte_adv && pace) begin
                    m_bytes++;
                    if (m_bytes == burst) begin m_mode = 3; m_bytes = 0; end
                end
            end else begin
                if (fall) m_mode = 2;
            end
            q_req.push_front(int'(dreq_n)); void'(q_req.pop_back());
            q_st.push_front(int'(start_pin)); void'(q_st.pop_back());
        end
    end

    task automatic chk(string tag, logic act_ok, logic exp_ok, logic act_p, logic exp_p);
        n_run++;
        if (act_ok !== exp_ok || act_p !== exp_p) begin
            n_fail++;
            $display("FAIL %s: xfer_ok=%b paused=%b expected xfer_ok=%b paused=%b",
                     tag, act_ok, act_p, exp_ok, exp_p);
        end
    endtask

    task automatic step(int k = 1);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            chk({phase, " model"}, xfer_ok, logic'(m_mode == 2), paused, logic'(m_mode == 3));
        end
    endtask

    task automatic pulse_go();
        go = 1'b1; step(); go = 1'b0;
    endtask

    task automatic finish_xfer();
        xfer_done = 1'b1; step(); xfer_done = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1
        step(3);
        chk("R1 in reset", xfer_ok, 1'b0, paused, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 after release", xfer_ok, 1'b0, paused, 1'b0);

        // R2
        phase = "R2";
        pulse_go();
        chk("R2 go starts", xfer_ok, 1'b1, paused, 1'b0);

        // R6: pacing disabled by enable, then by zero field
        phase = "R6";
        byte_adv = 1'b1; req_log2 = 4'd2;
        step(20);
        chk("R6 enable off", xfer_ok, 1'b1, paused, 1'b0);
        ext_pause_en = 1'b1; req_log2 = 4'd0;
        step(20);
        chk("R6 field zero", xfer_ok, 1'b1, paused, 1'b0);
        byte_adv = 1'b0;
        phase = "R9";
        finish_xfer();
        chk("R9 done idles", xfer_ok, 1'b0, paused, 1'b0);

        // R4: 4-byte bursts; request pin drops during the burst (R7 ignored edge)
        phase = "R4";
        req_log2 = 4'd2;
        pulse_go();
        dreq_n = 1'b0;
        byte_adv = 1'b1;
        step(3);
        chk("R4 before last byte", xfer_ok, 1'b1, paused, 1'b0);
        step();
        chk("R4 paused after 4", xfer_ok, 1'b0, paused, 1'b1);

        // R8 strobes during pause, R7 low level does not resume
        phase = "R7";
        step(8);
        chk("R7 level low no resume", xfer_ok, 1'b0, paused, 1'b1);
        byte_adv = 1'b0;
        dreq_n = 1'b1; step(4);
        dreq_n = 1'b0;
        step(2);
        chk("R7 before sync latency", xfer_ok, 1'b0, paused, 1'b1);
        step();
        chk("R7 resumed on edge", xfer_ok, 1'b1, paused, 1'b0);
        phase = "R8";
        dreq_n = 1'b1;
        byte_adv = 1'b1;
        step(3);
        chk("R8 full burst after pause strobes", xfer_ok, 1'b1, paused, 1'b0);
        step();
        chk("R8 paused after 4", xfer_ok, 1'b0, paused, 1'b1);
        byte_adv = 1'b0;

        // R9: end mid-burst, go in same cycle ignored, next burst full length
        phase = "R9";
        step(3); dreq_n = 1'b0; step(4); dreq_n = 1'b1;
        byte_adv = 1'b1; step(2); byte_adv = 1'b0;
        xfer_done = 1'b1; go = 1'b1; step(); xfer_done = 1'b0; go = 1'b0;
        chk("R9 done beats go", xfer_ok, 1'b0, paused, 1'b0);
        pulse_go();
        byte_adv = 1'b1;
        step(3);
        chk("R9 counter cleared", xfer_ok, 1'b1, paused, 1'b0);
        step();
        chk("R9 full burst", xfer_ok, 1'b0, paused, 1'b1);
        byte_adv = 1'b0;
        finish_xfer();

        // R3 and R10: external start
        phase = "R3";
        ext_start_en = 1'b1;
        pulse_go();
        step(5);
        chk("R3 R10 waiting", xfer_ok, 1'b0, paused, 1'b0);
        start_pin = 1'b1;
        step(2);
        chk("R3 within sync latency", xfer_ok, 1'b0, paused, 1'b0);
        step();
        chk("R3 started by pin", xfer_ok, 1'b1, paused, 1'b0);
        start_pin = 1'b0;
        finish_xfer();
        ext_start_en = 1'b0;

        // R5: field 15 clamps to 1024
        phase = "R5";
        req_log2 = 4'd15;
        pulse_go();
        byte_adv = 1'b1;
        step(1023);
        chk("R5 1023 bytes running", xfer_ok, 1'b1, paused, 1'b0);
        step();
        chk("R5 paused at 1024", xfer_ok, 1'b0, paused, 1'b1);
        byte_adv = 1'b0;
        finish_xfer();
        chk("R10 idle after done", xfer_ok, 1'b0, paused, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule